// File: doc/BRIEF.md
# Indexed Host Bus Port

This block is a byte-wide slave port for an external processor whose bus runs independently of the chip clock. The processor reaches a 256-location space through one address line. A write with the address line low sets an internal index. A read or write with the address line high then reaches the location that the index selects. The index can advance by one after every such data access, so a run of consecutive bytes needs only one index write.

Chip select, read strobe, write strobe and reset are all active low. The strobes, chip select, the address line and the incoming data byte pass through a synchroniser into the internal clock domain. An access sequencer then captures read data while the read strobe is held low, and commits write data once the write strobe is released. The outgoing byte leaves on a separate output together with an output-enable, and the tri-state buffer sits at the pad.

The lowest three locations hold control registers: an auto-increment enable, an interrupt enable mask and an event status byte. Every other location is a byte of the on-chip buffer memory. Internal logic raises status bits with one-cycle event pulses. The interrupt line reports any status bit that is also enabled. Each strobe must stay low for at least SYNC_STAGES+4 clock cycles, and the gap between accesses must be just as long.

Top module: `ibp_host_port`

## Requirements
- R1: While reset is low and after it is released, the index is 0x00, the auto-increment enable, the interrupt enable mask and the status byte are 0, `irq` is low and the sequencer is idle. The buffer contents are not cleared.
- R2: A write access with `a0` = 0 loads the data byte into the index. A read access with `a0` = 0 returns the current index and leaves it unchanged.
- R3: An access with `a0` = 1 reaches the location at the index. Location 0x00 is the control register, where bit 0 is the auto-increment enable and the other bits read as 0. Location 0x01 is the interrupt enable mask. Location 0x02 is the status byte. Locations 0x03 to 0xFF are buffer bytes that read back the last value written to them.
- R4: While auto-increment is disabled, an access with `a0` = 1 leaves the index unchanged.
- R5: While auto-increment is enabled, each access with `a0` = 1 adds one to the index. The enable value that counts is the one in effect before the access, so the write that sets the enable does not itself advance the index.
- R6: An auto-increment from index 0xFF gives 0x00.
- R7: `d_oe` is high only while `cs_n` and `rd_n` are both low. The returned byte on `d_out` stays steady while the read strobe is held.
- R8: A write takes the byte present while the strobe is low and commits it after the strobe rises. Strobes given while `cs_n` is high have no effect.
- R9: A one-cycle pulse on `evt_set[b]` sets status bit b. Writing the status location clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. An event pulse wins over a clear of the same bit in the same cycle.
- R10: `irq` is high exactly when some status bit is set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from the host, active low |
| rd_n | input | 1 | Read strobe from the host, active low |
| wr_n | input | 1 | Write strobe from the host, active low |
| a0 | input | 1 | Selects index (0) or data (1) |
| d_in | input | DW | Byte from the host data bus |
| d_out | output | DW | Byte returned to the host data bus |
| d_oe | output | 1 | Drive enable for the data bus pads |
| evt_set | input | DW | One-cycle event pulses that set status bits |
| irq | output | 1 | Interrupt request to the host, active high |

Sequencer states and transitions: IDLE goes to RD_HOLD on a selected read strobe, and to WR_HOLD on a selected write strobe (read has priority). RD_HOLD goes to RD_STEP when the read ends, and RD_STEP returns to IDLE. WR_HOLD goes to WR_APPLY when the write ends, and WR_APPLY returns to IDLE.

## Verification
The bench builds the block with DW = 8, AW = 8 and SYNC_STAGES = 2. At that size the whole index range is reachable, so streaming across 0xFE to 0x00 covers the wrap. The three register locations and the buffer share one index space, so one auto-incrementing run can move from the status byte into buffer bytes. Two synchroniser stages keep each host access short enough for long streaming runs, while the access timing still depends on the full synchroniser latency.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HOLD,
        ST_RD_STEP,
        ST_WR_HOLD,
        ST_WR_APPLY
    } ibp_state_e;

    localparam int unsigned IDX_CTRL         = 0;
    localparam int unsigned IDX_IRQ_EN       = 1;
    localparam int unsigned IDX_STATUS       = 2;
    localparam int unsigned NUM_REGS         = 3;
    localparam int unsigned CTRL_AUTOINC_BIT = 0;

endpackage

// File: rtl/ibp_sync.sv
module ibp_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] r;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= g_stage[s-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/ibp_regfile.sv
module ibp_regfile
    import ibp_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt_set,
    output logic          is_reg,
    output logic [DW-1:0] rdata,
    output logic          autoinc,
    output logic [DW-1:0] stat_o,
    output logic          irq
);

    logic          autoinc_q;
    logic [DW-1:0] en_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] clr_mask;

    assign is_reg = (addr < AW'(NUM_REGS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoinc_q <= 1'b0;
            en_q      <= '0;
        end else if (we) begin
            if (addr == AW'(IDX_CTRL))   autoinc_q <= wdata[CTRL_AUTOINC_BIT];
            if (addr == AW'(IDX_IRQ_EN)) en_q      <= wdata;
        end
    end

    assign clr_mask = (we && addr == AW'(IDX_STATUS)) ? wdata : '0;

    for (genvar b = 0; b < DW; b++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           stat_q[b] <= 1'b0;
            else if (evt_set[b])  stat_q[b] <= 1'b1;
            else if (clr_mask[b]) stat_q[b] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(IDX_CTRL))        rdata[CTRL_AUTOINC_BIT] = autoinc_q;
        else if (addr == AW'(IDX_IRQ_EN)) rdata = en_q;
        else if (addr == AW'(IDX_STATUS)) rdata = stat_q;
    end

    assign autoinc = autoinc_q;
    assign stat_o  = stat_q;
    assign irq     = |(stat_q & en_q);

endmodule

// File: rtl/ibp_buffer.sv
module ibp_buffer #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/ibp_host_port.sv
module ibp_host_port
    import ibp_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned AW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          a0,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe,
    input  logic [DW-1:0] evt_set,
    output logic          irq
);

    localparam int unsigned SW = DW + 4;
    localparam logic [SW-1:0] SYNC_RST = {{(DW+1){1'b0}}, 3'b111};

    logic [SW-1:0] raw_bus, syn_bus;
    logic          s_wr_n, s_rd_n, s_cs_n, s_a0;
    logic [DW-1:0] s_d;
    logic          rd_act, wr_act;

    ibp_state_e    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic          acc_a0_q;
    logic [DW-1:0] wd_q;
    logic [DW-1:0] rdata_q;

    logic          rd_capture, wr_track, commit_data, commit_idx, step_idx;
    logic          is_reg, autoinc;
    logic [DW-1:0] reg_rdata, buf_rdata, sel_rdata, stat_w;
    logic          stat_wr;

    assign raw_bus = {a0, d_in, cs_n, rd_n, wr_n};

    ibp_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_bus),
        .q    (syn_bus)
    );

    assign s_wr_n = syn_bus[0];
    assign s_rd_n = syn_bus[1];
    assign s_cs_n = syn_bus[2];
    assign s_d    = syn_bus[DW+2:3];
    assign s_a0   = syn_bus[DW+3];

    assign rd_act = !s_cs_n && !s_rd_n;
    assign wr_act = !s_cs_n && !s_wr_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_act)      state_d = ST_RD_HOLD;
                else if (wr_act) state_d = ST_WR_HOLD;
            end
            ST_RD_HOLD:  if (!rd_act) state_d = ST_RD_STEP;
            ST_RD_STEP:  state_d = ST_IDLE;
            ST_WR_HOLD:  if (!wr_act) state_d = ST_WR_APPLY;
            ST_WR_APPLY: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output decode of the sequencer
    always_comb begin
        rd_capture  = 1'b0;
        wr_track    = 1'b0;
        commit_data = 1'b0;
        commit_idx  = 1'b0;
        step_idx    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rd_capture = rd_act;
                wr_track   = !rd_act && wr_act;
            end
            ST_RD_HOLD: ;
            ST_RD_STEP: step_idx = acc_a0_q && autoinc;
            ST_WR_HOLD: wr_track = wr_act;
            ST_WR_APPLY: begin
                commit_data = acc_a0_q;
                commit_idx  = !acc_a0_q;
                step_idx    = acc_a0_q && autoinc;
            end
            default: ;
        endcase
    end

    // Access datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            acc_a0_q <= 1'b0;
            wd_q     <= '0;
            rdata_q  <= '0;
        end else begin
            if (rd_capture) begin
                acc_a0_q <= s_a0;
                rdata_q  <= s_a0 ? sel_rdata : DW'(idx_q);
            end
            if (wr_track) begin
                acc_a0_q <= s_a0;
                wd_q     <= s_d;
            end
            if (commit_idx)    idx_q <= AW'(wd_q);
            else if (step_idx) idx_q <= idx_q + AW'(1);
        end
    end

    ibp_regfile #(.DW(DW), .AW(AW)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (idx_q),
        .we     (commit_data && is_reg),
        .wdata  (wd_q),
        .evt_set(evt_set),
        .is_reg (is_reg),
        .rdata  (reg_rdata),
        .autoinc(autoinc),
        .stat_o (stat_w),
        .irq    (irq)
    );

    ibp_buffer #(.DW(DW), .AW(AW)) buf_i (
        .clk  (clk),
        .we   (commit_data && !is_reg),
        .addr (idx_q),
        .wdata(wd_q),
        .rdata(buf_rdata)
    );

    assign sel_rdata = is_reg ? reg_rdata : buf_rdata;
    assign stat_wr   = commit_data && (idx_q == AW'(IDX_STATUS));

    assign d_out = rdata_q;
    assign d_oe  = !cs_n && !rd_n;

endmodule

// File: rtl/ibp_host_port_chk.sv
module ibp_host_port_chk
    import ibp_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input ibp_state_e    state_q,
    input logic [AW-1:0] idx_q,
    input logic          acc_a0_q,
    input logic          autoinc,
    input logic [DW-1:0] d_out,
    input logic          irq,
    input logic [DW-1:0] stat_w,
    input logic          stat_wr
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (idx_q == '0 && !irq && state_q == ST_IDLE)); // R1

    AST_IDX_AT_ACCESS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> ($past(state_q) == ST_WR_APPLY || $past(state_q) == ST_RD_STEP)); // R2

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RD_STEP || state_q == ST_WR_APPLY) && acc_a0_q && !autoinc) |=> $stable(idx_q)); // R4

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RD_STEP || state_q == ST_WR_APPLY) && acc_a0_q && autoinc)
        |=> (idx_q == AW'($past(idx_q) + 1'b1))); // R5

    AST_RDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_HOLD && $past(state_q) == ST_RD_HOLD) |-> $stable(d_out)); // R7

    AST_STATUS_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_w) & ~stat_w)) |-> $past(stat_wr)); // R9

endmodule

bind ibp_host_port ibp_host_port_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .idx_q   (idx_q),
    .acc_a0_q(acc_a0_q),
    .autoinc (autoinc),
    .d_out   (d_out),
    .irq     (irq),
    .stat_w  (stat_w),
    .stat_wr (stat_wr)
);

// File: tb/ibp_host_port_tb_top.sv
`timescale 1ns/1ps
module ibp_host_port_tb_top;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] d_out;
    logic          d_oe;
    logic [DW-1:0] evt_set = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [DW-1:0] val;
        string         req;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     smp_ev;

    // Reference model state
    logic [DW-1:0] m_mem [256];
    logic [AW-1:0] m_idx = '0;
    logic          m_ainc = 1'b0;
    logic [DW-1:0] m_en = '0;
    logic [DW-1:0] m_stat = '0;

    always #4 clk = ~clk;

    ibp_host_port #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .evt_set(evt_set), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_read(input logic sel);
        if (!sel) return DW'(m_idx);
        case (m_idx)
            8'h00:   return {7'b0, m_ainc};
            8'h01:   return m_en;
            8'h02:   return m_stat;
            default: return m_mem[m_idx];
        endcase
    endfunction

    task automatic bus_wr(input logic sel, input logic [DW-1:0] v);
        logic step;
        @(negedge clk);
        a0 = sel; d_in = v; cs_n = 1'b0; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        step = sel && m_ainc;
        if (!sel) m_idx = v;
        else begin
            case (m_idx)
                8'h00:   m_ainc = v[0];
                8'h01:   m_en = v;
                8'h02:   m_stat = m_stat & ~v;
                default: m_mem[m_idx] = v;
            endcase
        end
        if (step) m_idx = m_idx + 8'd1;
    endtask

    task automatic bus_rd(input logic sel, input string req);
        sb_item_t it;
        it.val = model_read(sel);
        it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        a0 = sel; cs_n = 1'b0; rd_n = 1'b0;
        repeat (6) @(negedge clk);
        -> smp_ev;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
        if (sel && m_ainc) m_idx = m_idx + 8'd1;
    endtask

    task automatic pulse_evt(input logic [DW-1:0] mask);
        @(negedge clk);
        evt_set = mask;
        @(negedge clk);
        evt_set = '0;
        m_stat = m_stat | mask;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops expected bytes and compares against the returned data
    initial begin
        forever begin
            @(smp_ev);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.req, d_out, it.val);
                check("R7 oe during read", {7'b0, d_oe}, 8'h01);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 oe idle", {7'b0, d_oe}, 8'h00);
        bus_rd(1'b0, "R1 index");

        // R2: index load and readback
        bus_wr(1'b0, 8'h10);
        bus_rd(1'b0, "R2 index");

        // R3/R4: data access without auto-increment
        bus_wr(1'b1, 8'hA5);
        bus_rd(1'b0, "R4 index after write");
        bus_rd(1'b1, "R3 buffer byte");
        bus_rd(1'b0, "R4 index after read");

        // R5: enabling write does not step
        bus_wr(1'b0, 8'h00);
        bus_wr(1'b1, 8'h01);
        bus_rd(1'b0, "R5 no step on enabling write");
        bus_rd(1'b1, "R3 control reads enable");

        // R5: streaming writes then reads
        bus_wr(1'b0, 8'h20);
        for (int i = 0; i < 8; i++) bus_wr(1'b1, 8'(8'h30 + i * 7));
        bus_rd(1'b0, "R5 index after stream write");
        bus_wr(1'b0, 8'h20);
        for (int i = 0; i < 8; i++) bus_rd(1'b1, "R5 stream read");
        bus_rd(1'b0, "R5 index after stream read");

        // R6: wrap
        bus_wr(1'b0, 8'hFE);
        bus_wr(1'b1, 8'h11);
        bus_wr(1'b1, 8'h22);
        bus_rd(1'b0, "R6 wrap after write");
        bus_wr(1'b0, 8'hFE);
        bus_rd(1'b1, "R6 byte FE");
        bus_rd(1'b1, "R6 byte FF");
        bus_rd(1'b0, "R6 wrap after read");

        // R9/R10: status and interrupt
        pulse_evt(8'h08);
        check("R10 masked", {7'b0, irq}, 8'h00);
        bus_wr(1'b0, 8'h02);
        bus_rd(1'b1, "R9 status set");
        bus_wr(1'b0, 8'h01);
        bus_wr(1'b1, 8'h08);
        check("R10 enabled", {7'b0, irq}, 8'h01);
        bus_wr(1'b1, 8'h00);
        check("R9 write zero keeps", {7'b0, irq}, 8'h01);
        bus_wr(1'b0, 8'h02);
        bus_wr(1'b1, 8'h08);
        check("R9 write one clears", {7'b0, irq}, 8'h00);
        pulse_evt(8'h81);
        check("R10 other bits masked", {7'b0, irq}, {7'b0, |(m_stat & m_en)});
        bus_wr(1'b0, 8'h02);
        bus_rd(1'b1, "R9 two bits");

        // R8/R7: strobes with chip select high
        bus_wr(1'b0, 8'h40);
        @(negedge clk);
        a0 = 1'b0; d_in = 8'h55; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_rd(1'b0, "R8 deselected write ignored");
        @(negedge clk);
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 oe needs select", {7'b0, d_oe}, 8'h00);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset in mid-run
        pulse_evt(8'h08);
        check("R10 raised before reset", {7'b0, irq}, 8'h01);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_idx = '0; m_ainc = 1'b0; m_en = '0; m_stat = '0;
        repeat (3) @(negedge clk);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        bus_rd(1'b0, "R1 index after reset");
        bus_rd(1'b1, "R1 control after reset");
        bus_rd(1'b0, "R1 no step after reset");

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule